// File: doc/BRIEF.md
# Floppy Command Completion Status Unit

This unit closes out every command of a floppy disk controller. When the command sequencer signals that a command has ended, the unit returns the controller to idle and raises the done flag. If interrupts are enabled, it asserts an interrupt request. It then builds the status word by merging the condition flags reported by the command into a set of sticky status bits, and it recomputes the drive-dependent bits from the currently selected drive. It sets the summary error flag and places the finished status word in the data buffer register, where software can read it without a further command.

The sequencer also tells the unit when a command starts. Every accepted start clears done, error and the interrupt request. A start of a sector read, write or delete-write additionally clears the sticky status, keeping only the init-done bit. The interrupt request is a level: it stays up until a new command, an initialize, or the clearing of interrupt enable removes it.

Top module: `cmd_finish_unit`

## Requirements
- R1: A `cmdEnd` pulse while `busy` is high makes `busy` low and `doneBit` high after the next clock edge. The same edge loads `errCode` with `endCode`.
- R2: A `cmdStart` pulse while `busy` is low makes `busy` high and `doneBit`, `errBit` and `irq` low after the next clock edge. A `cmdStart` while busy is ignored.
- R3: At completion, `endFlags` is ORed into the sticky status bits. Those bits survive later commands that are not sector transfers.
- R4: The drive bits are rebuilt at every completion and are never taken from `endFlags`. Bit 8 (unit selected) is `driveSel`==1. Bit 7 (ready) is the selected drive's attached flag. Bit 5 (double density) is set when the selected drive is both attached and double density.
- R5: `errBit` is set at completion when `endCode` is nonzero or when the merged status has any of bits 0 (CRC), 3 (power fail), 4 (density error), 10 (word count overflow) or 11 (nonexistent memory). Bit 6 (deleted data) and bit 2 (init done) are not errors.
- R6: A start with `startRw` or `startDelWrite` clears every status bit except bit 2 (init done). `startDelWrite` also sets bit 6 (deleted data).
- R7: At completion, `dataReg` takes the new status word in its low 12 bits and zeros above. It holds that value until the next completion.
- R8: At completion, `irq` rises on the same edge as `doneBit` if `intEnable` is high, and stays low otherwise.
- R9: When `intEnable` rises while `doneBit` is high, `irq` rises one edge later. `intEnable` low forces `irq` low on the next edge.
- R10: An `initPulse` (or reset) clears `busy`, `doneBit`, `errBit`, `irq`, `statusWord`, `errCode` and `dataReg`.
- R11: A `cmdEnd` pulse while `busy` is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| initPulse | input | 1 | Controller initialize strobe |
| cmdStart | input | 1 | Command start strobe |
| startRw | input | 1 | Starting command is a sector read or write |
| startDelWrite | input | 1 | Starting command is a deleted-data write |
| cmdEnd | input | 1 | Command completion strobe |
| endFlags | input | 12 | Status flags raised by the ending command |
| endCode | input | CODE_W | Error code of the ending command |
| intEnable | input | 1 | Interrupt enable level |
| driveSel | input | SEL_W | Selected drive |
| driveAttached | input | NUM_DRIVES | Per-drive media present flags |
| driveDouble | input | NUM_DRIVES | Per-drive double density flags |
| busy | output | 1 | Command in progress (not idle) |
| doneBit | output | 1 | Command done flag |
| errBit | output | 1 | Summary error flag |
| irq | output | 1 | Interrupt request level |
| statusWord | output | 12 | Error and status word |
| errCode | output | CODE_W | Error code register |
| dataReg | output | DATA_W | Data buffer register |

## Verification
The bench chains commands so that a word-count overflow left by one command must still raise the error flag on a later clean command. A unit that cleared sticky bits on every start, or that took the error flag only from the code, would miss this. It ends a command with an unattached drive after one with a double density drive, and it feeds drive bits through the flag input. A unit that ORed the drive bits in instead of rebuilding them would show stale ready and density bits. It checks that a deleted-data write leaves bit 6 set without raising an error, that a completion pulse while idle changes nothing, and that raising interrupt enable after done produces the late interrupt a purely event-driven request would lose.

// File: rtl/cmd_finish_pkg.sv
package cmd_finish_pkg;

  localparam int STAT_W = 12;

  localparam int B_CRC    = 0;
  localparam int B_INIT   = 2;
  localparam int B_PWR    = 3;
  localparam int B_DENERR = 4;
  localparam int B_DBL    = 5;
  localparam int B_DEL    = 6;
  localparam int B_RDY    = 7;
  localparam int B_SEL    = 8;
  localparam int B_WCO    = 10;
  localparam int B_NXM    = 11;

  localparam logic [STAT_W-1:0] ONE_BIT   = STAT_W'(1);
  localparam logic [STAT_W-1:0] ERR_MASK  = (ONE_BIT << B_CRC) | (ONE_BIT << B_PWR) |
                                            (ONE_BIT << B_DENERR) | (ONE_BIT << B_WCO) |
                                            (ONE_BIT << B_NXM);
  localparam logic [STAT_W-1:0] LIVE_MASK = (ONE_BIT << B_SEL) | (ONE_BIT << B_RDY) |
                                            (ONE_BIT << B_DBL);
  localparam logic [STAT_W-1:0] KEEP_MASK = (ONE_BIT << B_INIT);
  localparam logic [STAT_W-1:0] DEL_MASK  = (ONE_BIT << B_DEL);

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic clrSticky;
    logic setDeleted;
    logic complete;
  } ctlStrobes_t;

endpackage

// File: rtl/cmd_finish_ctrl.sv
module cmd_finish_ctrl
  import cmd_finish_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        initPulse,
  input  logic        cmdStart,
  input  logic        startRw,
  input  logic        startDelWrite,
  input  logic        cmdEnd,
  input  logic        intEnable,
  input  logic        errHit,
  output ctlStrobes_t st,
  output logic        busy,
  output logic        doneBit,
  output logic        errBit,
  output logic        irq
);

  logic busyQ, doneQ, errQ, irqQ, ieQ;
  logic startOk, endOk, ieRise;
  logic irqNext;

  assign startOk = cmdStart && !busyQ && !initPulse;
  assign endOk   = cmdEnd && busyQ && !initPulse;
  assign ieRise  = intEnable && !ieQ;

  always_comb begin
    st            = '0;
    st.clrAll     = initPulse;
    st.clrSticky  = startOk && (startRw || startDelWrite);
    st.setDeleted = startOk && startDelWrite;
    st.complete   = endOk;
  end

  always_comb begin
    irqNext = irqQ;
    if (initPulse || startOk || !intEnable) irqNext = 1'b0;
    else if (endOk)                          irqNext = 1'b1;
    else if (ieRise && doneQ)                irqNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      irqQ  <= 1'b0;
      ieQ   <= 1'b0;
    end else begin
      ieQ  <= intEnable;
      irqQ <= irqNext;
      if (initPulse) begin
        busyQ <= 1'b0;
        doneQ <= 1'b0;
        errQ  <= 1'b0;
      end else if (startOk) begin
        busyQ <= 1'b1;
        doneQ <= 1'b0;
        errQ  <= 1'b0;
      end else if (endOk) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
        errQ  <= errHit;
      end
    end
  end

  assign busy    = busyQ;
  assign doneBit = doneQ;
  assign errBit  = errQ;
  assign irq     = irqQ;

  p_complete_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    endOk |=> (!busyQ && doneQ));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    startOk |=> (busyQ && !doneQ && !errQ && !irqQ));

  p_err_only_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errQ) |-> $past(endOk));

  p_ie_low_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !intEnable |=> !irqQ);

  p_idle_end_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdEnd && !busyQ && !cmdStart && !initPulse) |=> $stable(doneQ));

endmodule

// File: rtl/cmd_finish_dp.sv
module cmd_finish_dp
  import cmd_finish_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int CODE_W     = 8,
  parameter int DATA_W     = 16,
  parameter int SEL_W      = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctlStrobes_t           st,
  input  logic [STAT_W-1:0]     endFlags,
  input  logic [CODE_W-1:0]     endCode,
  input  logic [SEL_W-1:0]      driveSel,
  input  logic [NUM_DRIVES-1:0] driveAttached,
  input  logic [NUM_DRIVES-1:0] driveDouble,
  output logic                  errHit,
  output logic [STAT_W-1:0]     statusWord,
  output logic [CODE_W-1:0]     errCode,
  output logic [DATA_W-1:0]     dataReg
);

  logic [STAT_W-1:0]     statusQ, mergedStat, liveBits;
  logic [CODE_W-1:0]     codeQ;
  logic [DATA_W-1:0]     dataQ;
  logic [NUM_DRIVES-1:0] selHit;
  logic                  selAttached, selDouble;

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_sel
    assign selHit[g] = (driveSel == SEL_W'(g));
  end

  assign selAttached = |(selHit & driveAttached);
  assign selDouble   = |(selHit & driveAttached & driveDouble);

  always_comb begin
    liveBits         = '0;
    liveBits[B_SEL]  = (driveSel == SEL_W'(1));
    liveBits[B_RDY]  = selAttached;
    liveBits[B_DBL]  = selDouble;
    mergedStat       = ((statusQ | endFlags) & ~LIVE_MASK) | liveBits;
    errHit           = (endCode != '0) || ((mergedStat & ERR_MASK) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= '0;
      codeQ   <= '0;
      dataQ   <= '0;
    end else if (st.clrAll) begin
      statusQ <= '0;
      codeQ   <= '0;
      dataQ   <= '0;
    end else if (st.clrSticky) begin
      statusQ <= (statusQ & KEEP_MASK) | (st.setDeleted ? DEL_MASK : '0);
    end else if (st.complete) begin
      statusQ <= mergedStat;
      codeQ   <= endCode;
      dataQ   <= DATA_W'(mergedStat);
    end
  end

  assign statusWord = statusQ;
  assign errCode    = codeQ;
  assign dataReg    = dataQ;

  p_live_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st.complete |=> (statusQ[B_RDY] == $past(driveAttached[driveSel])));

  p_sticky_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st.clrSticky && !st.clrAll) |=> ((statusQ & ~(KEEP_MASK | DEL_MASK)) == '0));

  p_data_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st.complete && !st.clrAll) |=> (dataQ == DATA_W'(statusQ)));

  p_init_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st.clrAll |=> (statusQ == '0 && codeQ == '0 && dataQ == '0));

endmodule

// File: rtl/cmd_finish_unit.sv
module cmd_finish_unit
  import cmd_finish_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int CODE_W     = 8,
  parameter int DATA_W     = 16,
  localparam int SEL_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  initPulse,
  input  logic                  cmdStart,
  input  logic                  startRw,
  input  logic                  startDelWrite,
  input  logic                  cmdEnd,
  input  logic [STAT_W-1:0]     endFlags,
  input  logic [CODE_W-1:0]     endCode,
  input  logic                  intEnable,
  input  logic [SEL_W-1:0]      driveSel,
  input  logic [NUM_DRIVES-1:0] driveAttached,
  input  logic [NUM_DRIVES-1:0] driveDouble,
  output logic                  busy,
  output logic                  doneBit,
  output logic                  errBit,
  output logic                  irq,
  output logic [STAT_W-1:0]     statusWord,
  output logic [CODE_W-1:0]     errCode,
  output logic [DATA_W-1:0]     dataReg
);

  ctlStrobes_t st;
  logic        errHit;

  cmd_finish_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .initPulse     (initPulse),
    .cmdStart      (cmdStart),
    .startRw       (startRw),
    .startDelWrite (startDelWrite),
    .cmdEnd        (cmdEnd),
    .intEnable     (intEnable),
    .errHit        (errHit),
    .st            (st),
    .busy          (busy),
    .doneBit       (doneBit),
    .errBit        (errBit),
    .irq           (irq)
  );

  cmd_finish_dp #(
    .NUM_DRIVES (NUM_DRIVES),
    .CODE_W     (CODE_W),
    .DATA_W     (DATA_W),
    .SEL_W      (SEL_W)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .st            (st),
    .endFlags      (endFlags),
    .endCode       (endCode),
    .driveSel      (driveSel),
    .driveAttached (driveAttached),
    .driveDouble   (driveDouble),
    .errHit        (errHit),
    .statusWord    (statusWord),
    .errCode       (errCode),
    .dataReg       (dataReg)
  );

endmodule

// File: tb/cmd_finish_unit_tb_top.sv
`timescale 1ns/1ps
module cmd_finish_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        initPulse = 1'b0;
  logic        cmdStart = 1'b0;
  logic        startRw = 1'b0;
  logic        startDelWrite = 1'b0;
  logic        cmdEnd = 1'b0;
  logic [11:0] endFlags = '0;
  logic [7:0]  endCode = '0;
  logic        intEnable = 1'b0;
  logic [0:0]  driveSel = '0;
  logic [1:0]  driveAttached = '0;
  logic [1:0]  driveDouble = '0;
  logic        busy, doneBit, errBit, irq;
  logic [11:0] statusWord;
  logic [7:0]  errCode;
  logic [15:0] dataReg;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cmd_finish_unit dut_i (
    .clk(clk), .rst_n(rst_n), .initPulse(initPulse), .cmdStart(cmdStart),
    .startRw(startRw), .startDelWrite(startDelWrite), .cmdEnd(cmdEnd),
    .endFlags(endFlags), .endCode(endCode), .intEnable(intEnable),
    .driveSel(driveSel), .driveAttached(driveAttached), .driveDouble(driveDouble),
    .busy(busy), .doneBit(doneBit), .errBit(errBit), .irq(irq),
    .statusWord(statusWord), .errCode(errCode), .dataReg(dataReg)
  );

  // kind: 0 other, 1 read/write, 2 delete-write
  typedef struct packed {
    logic [1:0]  kind;
    logic [11:0] flags;
    logic [7:0]  code;
    logic        sel;
    logic [1:0]  att;
    logic [1:0]  dbl;
    logic        ie;
    logic [11:0] expStat;
    logic        expErr;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 12'h004, 8'h00, 1'b0, 2'b01, 2'b00, 1'b1, 12'h084, 1'b0, 1'b1}, // R4 ready, init kept
    '{2'd0, 12'h400, 8'h00, 1'b1, 2'b10, 2'b10, 1'b0, 12'h5A4, 1'b1, 1'b0}, // R5 wco, drive1 dd
    '{2'd0, 12'h000, 8'h00, 1'b0, 2'b00, 2'b11, 1'b1, 12'h404, 1'b1, 1'b1}, // R3 sticky, R4 stale
    '{2'd1, 12'h000, 8'h40, 1'b0, 2'b01, 2'b01, 1'b1, 12'h0A4, 1'b1, 1'b1}, // R6 clear, R5 code
    '{2'd2, 12'h000, 8'h00, 1'b1, 2'b11, 2'b00, 1'b1, 12'h1C4, 1'b0, 1'b1}, // R6 deleted data
    '{2'd0, 12'h1A0, 8'h00, 1'b0, 2'b00, 2'b00, 1'b0, 12'h044, 1'b0, 1'b0}, // R4 flags ignored
    '{2'd1, 12'h001, 8'h00, 1'b0, 2'b01, 2'b00, 1'b1, 12'h085, 1'b1, 1'b1}, // R5 crc
    '{2'd0, 12'h008, 8'h00, 1'b1, 2'b10, 2'b00, 1'b1, 12'h18D, 1'b1, 1'b1}, // R5 power fail
    '{2'd1, 12'h010, 8'h00, 1'b0, 2'b01, 2'b00, 1'b1, 12'h094, 1'b1, 1'b1}, // R5 density err
    '{2'd1, 12'h800, 8'h00, 1'b0, 2'b01, 2'b00, 1'b1, 12'h884, 1'b1, 1'b1}, // R5 nxm
    '{2'd1, 12'h000, 8'h00, 1'b0, 2'b01, 2'b01, 1'b1, 12'h0A4, 1'b0, 1'b1}  // R6 clean
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runCmd(input vec_t v);
    @(negedge clk);
    intEnable     = v.ie;
    driveSel      = v.sel;
    driveAttached = v.att;
    driveDouble   = v.dbl;
    cmdStart      = 1'b1;
    startRw       = (v.kind == 2'd1);
    startDelWrite = (v.kind == 2'd2);
    @(negedge clk);
    cmdStart = 1'b0; startRw = 1'b0; startDelWrite = 1'b0;
    check("R2 busy after start", 32'(busy), 32'd1);
    check("R2 done cleared", 32'(doneBit), 32'd0);
    endFlags = v.flags;
    endCode  = v.code;
    cmdEnd   = 1'b1;
    @(negedge clk);
    cmdEnd = 1'b0; endFlags = '0; endCode = '0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", 32'(busy), 32'd0);
    check("R10 done", 32'(doneBit), 32'd0);
    check("R10 irq", 32'(irq), 32'd0);
    check("R10 status", 32'(statusWord), 32'd0);
    check("R10 data", 32'(dataReg), 32'd0);

    // R11 completion while idle is ignored
    endFlags = 12'h800; endCode = 8'h55; cmdEnd = 1'b1;
    @(negedge clk);
    cmdEnd = 1'b0; endFlags = '0; endCode = '0;
    @(negedge clk);
    check("R11 done", 32'(doneBit), 32'd0);
    check("R11 status", 32'(statusWord), 32'd0);
    check("R11 code", 32'(errCode), 32'd0);
    check("R11 data", 32'(dataReg), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      runCmd(VECS[i]);
      check("R1 idle", 32'(busy), 32'd0);
      check("R1 done", 32'(doneBit), 32'd1);
      check("R1 code", 32'(errCode), 32'(VECS[i].code));
      check("R3 R4 R6 status", 32'(statusWord), 32'(VECS[i].expStat));
      check("R5 err", 32'(errBit), 32'(VECS[i].expErr));
      check("R7 data", 32'(dataReg), 32'(VECS[i].expStat));
      check("R8 irq", 32'(irq), 32'(VECS[i].expIrq));
    end

    // R7 data holds until next completion; R2 start while busy ignored
    @(negedge clk);
    cmdStart = 1'b1; startRw = 1'b1; intEnable = 1'b0;
    @(negedge clk);
    cmdStart = 1'b0; startRw = 1'b0;
    check("R7 data held", 32'(dataReg), 32'h0A4);
    cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    check("R2 busy kept", 32'(busy), 32'd1);
    cmdEnd = 1'b1; driveAttached = 2'b00; driveSel = 1'b0;
    @(negedge clk);
    cmdEnd = 1'b0;
    check("R8 no irq when disabled", 32'(irq), 32'd0);
    check("R6 cleared", 32'(statusWord), 32'h004);

    // R9 late enable raises irq, disable drops it
    intEnable = 1'b1;
    @(negedge clk);
    check("R9 irq on enable", 32'(irq), 32'd1);
    @(negedge clk);
    check("R9 irq held", 32'(irq), 32'd1);
    intEnable = 1'b0;
    @(negedge clk);
    check("R9 irq dropped", 32'(irq), 32'd0);

    // R10 init clears
    initPulse = 1'b1;
    @(negedge clk);
    initPulse = 1'b0;
    check("R10 init done", 32'(doneBit), 32'd0);
    check("R10 init status", 32'(statusWord), 32'd0);
    check("R10 init data", 32'(dataReg), 32'd0);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

endmodule